// File: doc/BRIEF.md
# Low-Power Sleep Sequencer for a Synchronous Memory

This block places a synchronous memory into a low-power sleep state and brings it back out. The sleep request arrives as an active-high level with no timing relation to the clock. The block passes it through a flop chain into the clock domain and steps a small state machine through entry, sleep and recovery, all within fixed cycle counts. While the memory sleeps, its contents are kept, but the data bus must stay undriven and no new access may start.

The controller drives three outputs for the surrounding memory logic. The first is a power-down flag. The second is an access-block line, which the address-strobe logic must honour. The third is an output-disable line that holds the data drivers at high impedance. The chip-select status tells the block whether an access is still in flight. If one is, and sleep begins, a one-cycle abandon pulse marks that access as invalid. Two usage errors set a sticky protocol-error flag: starting sleep while the device is selected, and any select or strobe activity inside the recovery window.

With the default parameters, entry and exit each take two clock edges. The synchronizer delay counts as part of those two edges.

Top module: `lp_sleep_seq`

## Requirements
- R1: While reset is asserted and just after it is released, all five outputs are low.
- R2: Suppose the sleep request is first sampled high at edge k. Then the access-block output goes high after edge k. The power-down flag and the output-disable go high after edge k+1.
- R3: Once entry has begun, it runs to completion even if the request falls again at once. The power-down flag is then high for at least one cycle before recovery runs.
- R4: Suppose the request is first sampled low at edge m while asleep. Then the power-down flag, output-disable and access-block all stay high after edge m and all go low after edge m+1.
- R5: Suppose the chip select is high at the edge where the power-down flag rises. Then the abandon output is high for exactly the one cycle after that edge, and low otherwise.
- R6: A select that is high at the edge where sleep begins sets the protocol-error flag.
- R7: A select or strobe sampled at edge m+1 of the recovery window sets the protocol-error flag.
- R8: Strobes while fully asleep, and strobes or selects while awake with no request, leave the error flag low. Once set, the flag stays high until reset.
- R9: Whenever the power-down flag is high, the access-block and output-disable outputs are high as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, high asks for sleep |
| sel_i | input | 1 | Chip-select status, high while the device is selected |
| strobe_i | input | 1 | High when any address strobe is asserted |
| sleep_o | output | 1 | Power-down flag |
| acc_block_o | output | 1 | New accesses must not be accepted while high |
| out_hiz_o | output | 1 | Forces the data outputs to high impedance |
| drop_o | output | 1 | One-cycle pulse: the in-flight access is abandoned |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench checks entry and exit latency edge by edge. A design that added a third synchronizer stage, or that let the state register miss the second edge, would show the power-down flag one cycle late. A short request pulse must still produce a full sleep and recovery; a design that dropped the entry part-way would never raise the flag. Select and strobe activity are placed on both sides of each window boundary. A recovery check that was one cycle off would then either miss the violation or flag a legal strobe on the first awake cycle. Selected entry is used to check that the abandon pulse lasts exactly one cycle and that the error flag stays set.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE  = 2'd0,
      ST_ENTER  = 2'd1,
      ST_ASLEEP = 2'd2,
      ST_EXIT   = 2'd3
   } slp_state_e;

   // counter width for a down-counter that holds values 0..len-1
   function automatic int unsigned cnt_width(input int unsigned len);
      return (len <= 2) ? 1 : $clog2(len);
   endfunction

endpackage

// File: rtl/lp_sleep_sync.sv
module lp_sleep_sync #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= async_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lp_sleep_timer.sv
module lp_sleep_timer #(
   parameter int unsigned LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);

   localparam int unsigned W = lp_sleep_pkg::cnt_width(LEN);
   localparam logic [W-1:0] START = W'(LEN - 1);

   logic [W-1:0] cnt_q;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("lp_sleep_timer: LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= START;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
   import lp_sleep_pkg::*;
#(
   parameter int unsigned ENTRY_EXTRA = 0,
   parameter int unsigned EXIT_EXTRA  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       sel_i,
   input  logic       strobe_i,
   input  logic       ent_done_i,
   input  logic       ext_done_i,
   output slp_state_e state_o,
   output logic       ent_load_o,
   output logic       ext_load_o,
   output logic       drop_o,
   output logic       err_o
);

   localparam bit HAS_ENTER = (ENTRY_EXTRA != 0);
   localparam bit HAS_EXIT  = (EXIT_EXTRA  != 0);

   slp_state_e state_q, state_d;
   logic       drop_q, err_q;
   logic       recov, bad_entry, bad_recov, sleep_start;

   always_comb begin
      state_d    = state_q;
      ent_load_o = 1'b0;
      ext_load_o = 1'b0;
      unique case (state_q)
         ST_AWAKE: begin
            if (req_i) begin
               if (HAS_ENTER) begin
                  state_d    = ST_ENTER;
                  ent_load_o = 1'b1;
               end else begin
                  state_d = ST_ASLEEP;
               end
            end
         end
         ST_ENTER: begin
            if (ent_done_i) state_d = ST_ASLEEP;
         end
         ST_ASLEEP: begin
            if (!req_i) begin
               if (HAS_EXIT) begin
                  state_d    = ST_EXIT;
                  ext_load_o = 1'b1;
               end else begin
                  state_d = ST_AWAKE;
               end
            end
         end
         ST_EXIT: begin
            if (ext_done_i) state_d = ST_AWAKE;
         end
         default: state_d = ST_AWAKE;
      endcase
   end

   assign recov       = ((state_q == ST_ASLEEP) && !req_i) || (state_q == ST_EXIT);
   assign bad_entry   = (state_q == ST_AWAKE) && req_i && sel_i;
   assign bad_recov   = recov && (sel_i || strobe_i);
   assign sleep_start = (state_d == ST_ASLEEP) && (state_q != ST_ASLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         drop_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         drop_q  <= sleep_start && sel_i;
         err_q   <= err_q || bad_entry || bad_recov;
      end
   end

   assign state_o = state_q;
   assign drop_o  = drop_q;
   assign err_o   = err_q;

endmodule

// File: rtl/lp_sleep_seq.sv
module lp_sleep_seq
   import lp_sleep_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ENTRY_CYC   = 2,
   parameter int unsigned EXIT_CYC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req_i,
   input  logic sel_i,
   input  logic strobe_i,
   output logic sleep_o,
   output logic acc_block_o,
   output logic out_hiz_o,
   output logic drop_o,
   output logic proto_err_o
);

   // The state register acts as the last synchronizer flop.
   localparam int unsigned PRE_STAGES  = SYNC_STAGES - 1;
   localparam int unsigned ENTRY_EXTRA = ENTRY_CYC - SYNC_STAGES;
   localparam int unsigned EXIT_EXTRA  = EXIT_CYC  - SYNC_STAGES;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lp_sleep_seq: SYNC_STAGES must be at least 2");
      end
      if (ENTRY_CYC < SYNC_STAGES || EXIT_CYC < SYNC_STAGES) begin : g_bad_cyc
         $error("lp_sleep_seq: entry and exit cycles must cover the synchronizer");
      end
   endgenerate

   logic       req_m;
   logic       ent_load, ext_load, ent_done, ext_done;
   slp_state_e state;

   lp_sleep_sync #(.STAGES(PRE_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sleep_req_i),
      .sync_o  (req_m)
   );

   generate
      if (ENTRY_EXTRA > 1) begin : g_ent_timer
         lp_sleep_timer #(.LEN(ENTRY_EXTRA)) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ent_load),
            .done_o (ent_done)
         );
      end else begin : g_ent_none
         assign ent_done = 1'b1;
      end
      if (EXIT_EXTRA > 1) begin : g_ext_timer
         lp_sleep_timer #(.LEN(EXIT_EXTRA)) u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ext_load),
            .done_o (ext_done)
         );
      end else begin : g_ext_none
         assign ext_done = 1'b1;
      end
   endgenerate

   lp_sleep_fsm #(
      .ENTRY_EXTRA (ENTRY_EXTRA),
      .EXIT_EXTRA  (EXIT_EXTRA)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_m),
      .sel_i      (sel_i),
      .strobe_i   (strobe_i),
      .ent_done_i (ent_done),
      .ext_done_i (ext_done),
      .state_o    (state),
      .ent_load_o (ent_load),
      .ext_load_o (ext_load),
      .drop_o     (drop_o),
      .err_o      (proto_err_o)
   );

   assign sleep_o     = (state == ST_ASLEEP);
   assign out_hiz_o   = (state != ST_AWAKE);
   assign acc_block_o = out_hiz_o || req_m;

endmodule

// File: rtl/lp_sleep_seq_chk.sv
module lp_sleep_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_o,
   input logic acc_block_o,
   input logic out_hiz_o,
   input logic drop_o,
   input logic proto_err_o
);

   // R9
   sleep_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (acc_block_o && out_hiz_o));

   // R2
   entry_block_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(acc_block_o));

   // R5
   drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |=> !drop_o);

   // R5
   drop_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> $rose(sleep_o));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);

endmodule

bind lp_sleep_seq lp_sleep_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_o     (sleep_o),
   .acc_block_o (acc_block_o),
   .out_hiz_o   (out_hiz_o),
   .drop_o      (drop_o),
   .proto_err_o (proto_err_o)
);

// File: tb/lp_sleep_seq_tb.sv
module lp_sleep_seq_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, sel = 1'b0, stb = 1'b0;
   logic sleep_w, blk_w, hiz_w, drop_w, err_w;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   lp_sleep_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req_i (req),
      .sel_i       (sel),
      .strobe_i    (stb),
      .sleep_o     (sleep_w),
      .acc_block_o (blk_w),
      .out_hiz_o   (hiz_w),
      .drop_o      (drop_w),
      .proto_err_o (err_w)
   );

   function automatic logic [4:0] outs();
      return {sleep_w, blk_w, hiz_w, drop_w, err_w};
   endfunction

   task automatic check(input logic [4:0] exp, input string tag);
      n_tests++;
      if (outs() !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs {sleep,blk,hiz,drop,err} got %b expected %b", tag, outs(), exp);
      end
   endtask

   // driver: set inputs before the next edge, queue the outputs expected after it
   task automatic step(input logic z, input logic s, input logic b,
                       input logic [4:0] exp, input string tag);
      @(negedge clk);
      req = z; sel = s; stb = b;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      req = 1'b0; sel = 1'b0; stb = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(5'b00000, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(5'b00000, "R1 after reset");
   endtask

   // monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() != 0) check(exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R2 R4 R8 R9: clean entry, strobes while asleep, exit, legal strobe after
      step(1, 0, 0, 5'b01000, "R2 block after first edge");
      step(1, 0, 0, 5'b11100, "R2 asleep after second edge");
      step(1, 0, 1, 5'b11100, "R8 strobe while asleep, R9");
      step(1, 0, 1, 5'b11100, "R9 asleep holds");
      step(0, 0, 0, 5'b11100, "R4 still blocked in recovery");
      step(0, 0, 0, 5'b00000, "R4 awake after second edge");
      step(0, 0, 1, 5'b00000, "R8 strobe after recovery");
      step(0, 1, 1, 5'b00000, "R8 select and strobe while awake");
      // R3: one-cycle request pulse
      step(1, 0, 0, 5'b01000, "R3 pulse seen");
      step(0, 0, 0, 5'b11100, "R3 entry completes");
      step(0, 0, 0, 5'b00000, "R3 recovery completes");
      step(0, 0, 0, 5'b00000, "R3 idle");
      // R7: select during recovery
      step(1, 0, 0, 5'b01000, "R7 setup");
      step(1, 0, 0, 5'b11100, "R7 setup asleep");
      step(0, 0, 0, 5'b11100, "R7 recovery");
      step(0, 1, 0, 5'b00001, "R7 select in recovery");
      step(0, 0, 0, 5'b00001, "R8 error sticky");
      repeat (2) @(negedge clk);
      do_reset();
      // R7: strobe during recovery
      step(1, 0, 0, 5'b01000, "R7 setup");
      step(1, 0, 0, 5'b11100, "R7 setup asleep");
      step(0, 0, 0, 5'b11100, "R7 recovery");
      step(0, 0, 1, 5'b00001, "R7 strobe in recovery");
      step(0, 0, 0, 5'b00001, "R8 error sticky");
      repeat (2) @(negedge clk);
      do_reset();
      // R5 R6: entry while selected
      step(1, 1, 0, 5'b01000, "R6 no error before entry edge");
      step(1, 1, 0, 5'b11111, "R5 R6 abandon and error at entry");
      step(1, 0, 0, 5'b11101, "R5 abandon lasts one cycle");
      step(0, 0, 0, 5'b11101, "R4 recovery");
      step(0, 0, 0, 5'b00001, "R4 awake, R8 error kept");
      repeat (2) @(negedge clk);
      do_reset();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule